// File: doc/BRIEF.md
# Ethernet PHY Basic Mode Control and Status Registers

This block is the management-side register file for the basic mode of a 10/100 Ethernet physical layer. It holds a 16-bit control word and a 16-bit read-only status word. A simple synchronous register port gives access to both. Reads are combinational from the selected address. A write takes effect on the clock edge where `reg_wr` is high. The port has no valid/ready handshake and no back-pressure, because every access completes in one cycle and the block can never stall it.

Several control bits come from strap inputs. Their defaults are taken from the straps while `rst_n` is held low, and again on every software reset. Writing the reset bit or the restart bit produces single-cycle pulses, and both bits always read back as 0. The block drives the loopback, power-down, isolate and collision-test controls directly. It also keeps registered copies of the effective speed and duplex. These copies follow the manual bits when auto-negotiation is off, and the negotiated result when it is on.

Software reset behaves differently while power-down is set. A write with the reset bit set only takes the block out of power-down. A second such write performs the real reset and samples the straps again.

Top module: `phy_basic_regs`

## Requirements
- R1: While `rst_n` is low on a clock edge, the control word loads the strap defaults. Bit 13 takes `strap_speed100`, bit 12 takes `strap_an_en`, bit 10 takes `strap_isolate`, bit 8 takes the inverse of `strap_half_dup`, and every other bit is 0. Both pulses and both effective outputs are 0.
- R2: The control word is at address 0. Bits 14 (loopback), 13 (speed, 1 = 100 Mb/s), 12 (auto-negotiation enable), 11 (power-down), 10 (isolate), 8 (duplex, 1 = full) and 7 (collision test) are read/write. Bits 14, 11, 10 and 7 drive `loopback`, `pwr_down`, `isolate` and `col_test`.
- R3: Bits 15 (reset), 9 (restart) and 6:0 of the control word always read 0.
- R4: A control write with bit 9 = 1 and bit 15 = 0 raises `an_restart_pulse` for exactly the one cycle after the write edge.
- R5: A control write with bit 15 = 1 while power-down is clear reloads the strap defaults of R1, using the straps present at the write edge, and ignores the other data bits. In the cycle after the edge, `soft_rst_pulse` and `an_restart_pulse` are each high, and only for that cycle.
- R6: A control write with bit 15 = 1 while power-down is set clears only bit 11. The other bits keep their values and no pulse is raised. A second such write then acts as R5.
- R7: With bit 12 = 0, `eff_speed100` and `eff_full_dup` equal bits 13 and 8 one cycle after the control word holds them.
- R8: With bit 12 = 1, an edge where `an_done` is high loads `an_speed100` and `an_full_dup` into the effective outputs. On edges where `an_done` is low, the effective outputs hold.
- R9: The status word is at address 1 and reads 0x7000. Bit 15 (T4 ability) is 0, and bits 14, 13 and 12 (100 full, 100 half and 10 full ability) are 1. Writes to address 1 change nothing.
- R10: Reads from any address other than 0 and 1 return 0x0000, and writes to them leave the control word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads strap defaults |
| strap_speed100 | input | 1 | Strap default for the speed bit |
| strap_an_en | input | 1 | Strap default for auto-negotiation enable |
| strap_isolate | input | 1 | Strap default for isolate |
| strap_half_dup | input | 1 | Strap; the duplex bit defaults to its inverse |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write enable, sampled on the clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| an_done | input | 1 | Negotiated result valid this cycle |
| an_speed100 | input | 1 | Negotiated speed, 1 = 100 Mb/s |
| an_full_dup | input | 1 | Negotiated duplex, 1 = full |
| soft_rst_pulse | output | 1 | One-cycle software reset pulse |
| an_restart_pulse | output | 1 | One-cycle restart-negotiation pulse |
| pwr_down | output | 1 | Power-down control |
| isolate | output | 1 | Isolate from MAC interface |
| loopback | output | 1 | Loopback control |
| col_test | output | 1 | Collision test control |
| eff_speed100 | output | 1 | Registered effective speed |
| eff_full_dup | output | 1 | Registered effective duplex |

## Verification
The assertions check, on every cycle, the fixed read values of the status word and of the reserved and self-clearing control bits. They also check the relation between a reset-bit write and the pulse or power-down exit that follows it, and how the effective outputs track either the manual bits or the negotiated result. Other behaviours can only be shown by the bench's scenarios: that a software reset samples the straps present at that moment, that a power-down exit leaves the other bits untouched and that a second reset write then completes the reset, and that writes to unmapped or read-only addresses leave the control word intact.

// File: rtl/phy_bcr_pkg.sv
package phy_bcr_pkg;

  localparam int DATA_W = 16;

  // bit positions inside the control word (software-visible layout)
  localparam int B_RST     = 15;
  localparam int B_LOOP    = 14;
  localparam int B_SPD     = 13;
  localparam int B_AN      = 12;
  localparam int B_PD      = 11;
  localparam int B_ISO     = 10;
  localparam int B_RESTART = 9;
  localparam int B_DUP     = 8;
  localparam int B_COL     = 7;

  // ability bits of the status word
  localparam logic ABIL_T4      = 1'b0;
  localparam logic ABIL_100_FD  = 1'b1;
  localparam logic ABIL_100_HD  = 1'b1;
  localparam logic ABIL_10_FD   = 1'b1;
  localparam logic [DATA_W-1:0] STATUS_WORD =
    {ABIL_T4, ABIL_100_FD, ABIL_100_HD, ABIL_10_FD, 12'h000};

  typedef struct packed {
    logic loopback;
    logic speed100;
    logic an_en;
    logic pwr_down;
    logic isolate;
    logic full_dup;
    logic col_test;
  } bcr_t;

  function automatic bcr_t bcr_from_word(input logic [DATA_W-1:0] w);
    bcr_t c;
    c.loopback = w[B_LOOP];
    c.speed100 = w[B_SPD];
    c.an_en    = w[B_AN];
    c.pwr_down = w[B_PD];
    c.isolate  = w[B_ISO];
    c.full_dup = w[B_DUP];
    c.col_test = w[B_COL];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] bcr_to_word(input bcr_t c);
    logic [DATA_W-1:0] w;
    w          = '0;
    w[B_LOOP]  = c.loopback;
    w[B_SPD]   = c.speed100;
    w[B_AN]    = c.an_en;
    w[B_PD]    = c.pwr_down;
    w[B_ISO]   = c.isolate;
    w[B_DUP]   = c.full_dup;
    w[B_COL]   = c.col_test;
    return w;
  endfunction

  function automatic bcr_t bcr_strap_defaults(input logic spd, input logic an,
                                              input logic iso, input logic half);
    bcr_t c;
    c          = '0;
    c.speed100 = spd;
    c.an_en    = an;
    c.isolate  = iso;
    c.full_dup = ~half;
    return c;
  endfunction

endpackage

// File: rtl/phy_bcr_ctrl.sv
module phy_bcr_ctrl
  import phy_bcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_speed100,
  input  logic              strap_an_en,
  input  logic              strap_isolate,
  input  logic              strap_half_dup,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  output bcr_t              ctrl_q,
  output logic              soft_rst_pulse,
  output logic              an_restart_pulse
);

  bcr_t defaults;
  bcr_t ctrl_d;
  logic rst_hit;
  logic pd_exit;
  logic restart_hit;

  always_comb begin
    defaults    = bcr_strap_defaults(strap_speed100, strap_an_en,
                                     strap_isolate, strap_half_dup);
    rst_hit     = ctrl_wr && wdata[B_RST] && !ctrl_q.pwr_down;
    pd_exit     = ctrl_wr && wdata[B_RST] && ctrl_q.pwr_down;
    restart_hit = ctrl_wr && !wdata[B_RST] && wdata[B_RESTART];
    ctrl_d      = ctrl_q;
    if (rst_hit) begin
      ctrl_d = defaults;
    end else if (pd_exit) begin
      ctrl_d.pwr_down = 1'b0;
    end else if (ctrl_wr) begin
      ctrl_d = bcr_from_word(wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q           <= defaults;
      soft_rst_pulse   <= 1'b0;
      an_restart_pulse <= 1'b0;
    end else begin
      ctrl_q           <= ctrl_d;
      soft_rst_pulse   <= rst_hit;
      an_restart_pulse <= rst_hit || restart_hit;
    end
  end

endmodule

// File: rtl/phy_bcr_mode.sv
module phy_bcr_mode #(
  parameter int N_LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               an_en,
  input  logic               an_done,
  input  logic [N_LANES-1:0] manual,
  input  logic [N_LANES-1:0] negotiated,
  output logic [N_LANES-1:0] eff
);

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic nxt;
    always_comb begin
      if (!an_en)       nxt = manual[g];
      else if (an_done) nxt = negotiated[g];
      else              nxt = eff[g];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) eff[g] <= 1'b0;
      else        eff[g] <= nxt;
    end
  end

endmodule

// File: rtl/phy_bcr_rdmux.sv
module phy_bcr_rdmux
  import phy_bcr_pkg::*;
#(
  parameter int                ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1)
) (
  input  logic [ADDR_W-1:0] addr,
  input  bcr_t              ctrl_q,
  output logic [DATA_W-1:0] rdata
);

  always_comb begin
    if (addr == CTRL_ADDR)      rdata = bcr_to_word(ctrl_q);
    else if (addr == STAT_ADDR) rdata = STATUS_WORD;
    else                        rdata = '0;
  end

endmodule

// File: rtl/phy_basic_regs.sv
module phy_basic_regs
  import phy_bcr_pkg::*;
#(
  parameter int                ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_speed100,
  input  logic              strap_an_en,
  input  logic              strap_isolate,
  input  logic              strap_half_dup,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              an_done,
  input  logic              an_speed100,
  input  logic              an_full_dup,
  output logic              soft_rst_pulse,
  output logic              an_restart_pulse,
  output logic              pwr_down,
  output logic              isolate,
  output logic              loopback,
  output logic              col_test,
  output logic              eff_speed100,
  output logic              eff_full_dup
);

  localparam int LANES = 2;

  bcr_t             ctrl_q;
  logic             ctrl_wr;
  logic [LANES-1:0] eff;

  assign ctrl_wr = reg_wr && (reg_addr == CTRL_ADDR);

  phy_bcr_ctrl u_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .strap_speed100   (strap_speed100),
    .strap_an_en      (strap_an_en),
    .strap_isolate    (strap_isolate),
    .strap_half_dup   (strap_half_dup),
    .ctrl_wr          (ctrl_wr),
    .wdata            (reg_wdata),
    .ctrl_q           (ctrl_q),
    .soft_rst_pulse   (soft_rst_pulse),
    .an_restart_pulse (an_restart_pulse)
  );

  // lane 1 = speed, lane 0 = duplex
  phy_bcr_mode #(.N_LANES(LANES)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .an_en      (ctrl_q.an_en),
    .an_done    (an_done),
    .manual     ({ctrl_q.speed100, ctrl_q.full_dup}),
    .negotiated ({an_speed100, an_full_dup}),
    .eff        (eff)
  );

  phy_bcr_rdmux #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .STAT_ADDR (STAT_ADDR)
  ) u_rdmux (
    .addr   (reg_addr),
    .ctrl_q (ctrl_q),
    .rdata  (reg_rdata)
  );

  assign pwr_down     = ctrl_q.pwr_down;
  assign isolate      = ctrl_q.isolate;
  assign loopback     = ctrl_q.loopback;
  assign col_test     = ctrl_q.col_test;
  assign eff_speed100 = eff[1];
  assign eff_full_dup = eff[0];

endmodule

// File: rtl/phy_basic_regs_chk.sv
module phy_basic_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  reg_addr,
  input logic        reg_wr,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic        an_done,
  input logic        an_speed100,
  input logic        an_full_dup,
  input logic        soft_rst_pulse,
  input logic        an_restart_pulse,
  input logic        pwr_down,
  input logic        eff_speed100,
  input logic        eff_full_dup,
  input logic        c_an_en,
  input logic        c_speed100,
  input logic        c_full_dup
);

  logic rst_wr;
  assign rst_wr = reg_wr && (reg_addr == 5'd0) && reg_wdata[15];

  // R3
  ctrl_fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 5'd0) |-> (reg_rdata[15] == 1'b0 && reg_rdata[9] == 1'b0 && reg_rdata[6:0] == 7'd0));

  // R9
  status_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 5'd1) |-> (reg_rdata == 16'h7000));

  // R4
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 5'd0 && !reg_wdata[15] && reg_wdata[9]) |=> an_restart_pulse);

  // R5
  soft_reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_wr && !pwr_down) |=> (soft_rst_pulse && an_restart_pulse));

  // R5
  soft_reset_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> $past(rst_wr && !pwr_down));

  // R6
  pd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_wr && pwr_down) |=> (!pwr_down && !soft_rst_pulse));

  // R7
  manual_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c_an_en |=> (eff_speed100 == $past(c_speed100) && eff_full_dup == $past(c_full_dup)));

  // R8
  neg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_an_en && an_done) |=> (eff_speed100 == $past(an_speed100) && eff_full_dup == $past(an_full_dup)));

  // R8
  neg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_an_en && !an_done) |=> ($stable(eff_speed100) && $stable(eff_full_dup)));

endmodule

bind phy_basic_regs phy_basic_regs_chk chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .reg_addr         (reg_addr),
  .reg_wr           (reg_wr),
  .reg_wdata        (reg_wdata),
  .reg_rdata        (reg_rdata),
  .an_done          (an_done),
  .an_speed100      (an_speed100),
  .an_full_dup      (an_full_dup),
  .soft_rst_pulse   (soft_rst_pulse),
  .an_restart_pulse (an_restart_pulse),
  .pwr_down         (pwr_down),
  .eff_speed100     (eff_speed100),
  .eff_full_dup     (eff_full_dup),
  .c_an_en          (ctrl_q.an_en),
  .c_speed100       (ctrl_q.speed100),
  .c_full_dup       (ctrl_q.full_dup)
);

// File: tb/phy_basic_regs_tb_top.sv
`timescale 1ns/1ps
module phy_basic_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_speed100 = 1'b1, strap_an_en = 1'b0, strap_isolate = 1'b0, strap_half_dup = 1'b0;
  logic [4:0]  reg_addr = 5'd0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        an_done = 1'b0, an_speed100 = 1'b0, an_full_dup = 1'b0;
  logic        soft_rst_pulse, an_restart_pulse, pwr_down, isolate, loopback, col_test;
  logic        eff_speed100, eff_full_dup;

  always #5 clk = ~clk;

  phy_basic_regs dut_i (.*);

  typedef struct {
    int          cyc;
    bit          is_out;
    logic [15:0] exp;
    logic [15:0] mask;
    string       req;
  } item_t;

  item_t sb_q[$];
  int    cyc = 0;
  int    n_vec = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;
  item_t it;
  logic [15:0] obs;
  logic [7:0]  outs;

  // outs bit order: soft, restart, pd, iso, loop, col, eff_spd, eff_full
  assign outs = {soft_rst_pulse, an_restart_pulse, pwr_down, isolate,
                 loopback, col_test, eff_speed100, eff_full_dup};

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items due this cycle and compares
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
      it  = sb_q.pop_front();
      obs = it.is_out ? {8'h00, outs} : reg_rdata;
      n_vec++;
      if ((obs & it.mask) !== (it.exp & it.mask)) begin
        n_bad++;
        $display("FAIL %s: %s got %h expected %h (mask %h)", it.req,
                 it.is_out ? "outputs" : "rdata", obs & it.mask, it.exp & it.mask, it.mask);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    step();
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    step();
    reg_wr    = 1'b0;
  endtask

  // driver side of the scoreboard: pushes expectations for this cycle
  task automatic chk(input logic [4:0] a, input logic [15:0] erd, input bit use_rd,
                     input logic [7:0] eo, input logic [7:0] mo, input string r);
    reg_addr = a;
    if (use_rd) sb_q.push_back('{cyc, 1'b0, erd, 16'hFFFF, r});
    if (mo != 8'h00) sb_q.push_back('{cyc, 1'b1, {8'h00, eo}, {8'h00, mo}, r});
    @(negedge clk); #1;
    step();
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1: straps speed=1 an=0 iso=0 half=0 -> 0x2100, all outputs low
    chk(5'd0, 16'h2100, 1, 8'h00, 8'hFF, "R1");
    rst_n = 1'b1;
    step();
    // R7: manual mode, eff follows bits 13 and 8
    chk(5'd0, 16'h2100, 1, 8'h03, 8'hFF, "R7");
    // R9 status
    chk(5'd1, 16'h7000, 1, 8'h00, 8'h00, "R9");

    // R2: loopback, isolate, col test; speed/duplex cleared
    wr(5'd0, 16'h4480);
    chk(5'd0, 16'h4480, 1, 8'h1F, 8'hFF, "R2");
    chk(5'd0, 16'h4480, 1, 8'h1C, 8'hFF, "R7");

    // R4 / R3: restart plus reserved bits
    wr(5'd0, 16'h027F);
    chk(5'd0, 16'h0000, 1, 8'h40, 8'hFF, "R4");
    chk(5'd0, 16'h0000, 1, 8'h00, 8'hFF, "R3");

    // R10: unmapped address
    wr(5'd5, 16'hFFFF);
    chk(5'd0, 16'h0000, 1, 8'h00, 8'hFF, "R10");
    chk(5'd5, 16'h0000, 1, 8'h00, 8'h00, "R10");
    chk(5'd31, 16'h0000, 1, 8'h00, 8'h00, "R10");

    // R9: write to status has no effect
    wr(5'd1, 16'hFFFF);
    chk(5'd1, 16'h7000, 1, 8'h00, 8'h00, "R9");
    chk(5'd0, 16'h0000, 1, 8'h00, 8'hFF, "R9");

    // R8: negotiation enabled, result not valid -> hold
    an_speed100 = 1'b1; an_full_dup = 1'b1;
    wr(5'd0, 16'h1000);
    chk(5'd0, 16'h1000, 1, 8'h00, 8'hFF, "R8");
    chk(5'd0, 16'h1000, 1, 8'h00, 8'hFF, "R8");
    an_done = 1'b1; an_speed100 = 1'b1; an_full_dup = 1'b0;
    step();
    an_done = 1'b0; an_full_dup = 1'b1;
    chk(5'd0, 16'h1000, 1, 8'h02, 8'hFF, "R8");
    chk(5'd0, 16'h1000, 1, 8'h02, 8'hFF, "R8");

    // R5: soft reset samples new straps -> 0x1400
    strap_speed100 = 1'b0; strap_an_en = 1'b1; strap_isolate = 1'b1; strap_half_dup = 1'b1;
    wr(5'd0, 16'hFFFF);
    chk(5'd0, 16'h1400, 1, 8'hD2, 8'hFF, "R5");
    chk(5'd0, 16'h1400, 1, 8'h00, 8'hC0, "R5");

    // R6: power-down exit takes two reset writes
    wr(5'd0, 16'h5C00);
    chk(5'd0, 16'h5C00, 1, 8'h38, 8'hFC, "R6");
    strap_speed100 = 1'b1; strap_an_en = 1'b0; strap_isolate = 1'b0; strap_half_dup = 1'b0;
    wr(5'd0, 16'h8000);
    chk(5'd0, 16'h5400, 1, 8'h18, 8'hFC, "R6");
    wr(5'd0, 16'h8000);
    chk(5'd0, 16'h2100, 1, 8'hC0, 8'hFC, "R6");
    chk(5'd0, 16'h2100, 1, 8'h03, 8'hFF, "R5");

    step();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule